// File: doc/BRIEF.md
# DDR2 Bank Command Legality Monitor

This block watches a DDR2 command bus and, for every bank, follows what the memory would be doing. Each clock it turns the chip-select, row-strobe, column-strobe and write-enable lines into a command. It reports that command together with the bank it targets. It then checks whether the targeted bank is in a state that allows the command.

Each bank has a six-state tracker: idle, activating, row open, reading, writing and precharging. Per-bank down-counters time the activate-to-column delay, the precharge recovery delay and the length of the current burst. The burst length comes from a field captured when the main mode register is loaded.

A command that the bank's state does not allow raises a single-cycle violation flag, which carries the command code and the bank number. The tracker still takes up the command, so checking stays meaningful after an error. `NUM_BANKS` must be a power of two.

Top module: `ddr2_cmd_legality_mon`

## Requirements
- R1: When a command is decoded, `cmd_seen` is high one clock edge later. `cmd_code` then shows the command and `cmd_bank` shows `ba`. With `cs_n` low, {ras_n,cas_n,we_n} decode as follows: 111 = NOP (code 1), 011 = ACTIVATE (2), 101 = READ (3), 100 = WRITE (4), 010 = PRECHARGE (5), 001 = REFRESH (6) and 000 = LOAD MODE (7). The unused pattern 110 reports as NOP (1).
- R2: A command is decoded only when `cke` is high in the current cycle and was also high in the previous cycle. Otherwise `cmd_seen`, `cmd_code`, `cmd_bank` and `viol` are all 0 and no bank changes state. The first cycle after reset counts as having had `cke` low before it.
- R3: When `cs_n` is high, the command is DESELECT (code 0) whatever the other lines are. It is never flagged and it changes no bank.
- R4: ACTIVATE, REFRESH and LOAD MODE are legal only when the bank addressed by `ba` is idle. Otherwise they are flagged. REFRESH and LOAD MODE change no bank state.
- R5: After an ACTIVATE, the bank is row-open only once `T_RCD` clocks have passed. A READ, WRITE or PRECHARGE to that bank before then is flagged; one exactly `T_RCD` cycles after the ACTIVATE is legal.
- R6: After a PRECHARGE, the bank becomes idle once `T_RP` clocks have passed. An ACTIVATE to that bank earlier than that is flagged; one exactly `T_RP` cycles after the PRECHARGE is legal.
- R7: A READ or WRITE burst occupies BL/2 clocks, counting the command's own cycle. With a burst length of 4, any READ, WRITE or PRECHARGE to that bank in the next cycle is flagged.
- R8: With a burst length of 8, a READ or WRITE to a bank that is reading or writing starts a new burst and is legal. A PRECHARGE there is also legal.
- R9: A LOAD MODE with `ba` = 0 sets the burst length to 4 when `addr_lo` = 3'b010 and to 8 when `addr_lo` = 3'b011. Any other value leaves it unchanged. The burst length is 4 after reset.
- R10: A violation drives `viol` high for one cycle, one edge after the command. `viol_cmd` and `viol_bank` equal that command's code and bank. `viol` is low in any cycle that follows a legal command.
- R11: READ, WRITE and PRECHARGE are flagged when the bank is idle, activating or precharging. The bank still enters the reading, writing or precharging state the command names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable line of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address; mode register select during LOAD MODE |
| addr_lo | input | 3 | Low address bits; burst-length field during LOAD MODE |
| cmd_seen | output | 1 | A command was decoded in the previous cycle |
| cmd_code | output | 3 | Code of the decoded command |
| cmd_bank | output | BA_W | Bank of the decoded command |
| viol | output | 1 | One-cycle pulse: the previous command was illegal |
| viol_cmd | output | 3 | Code of the illegal command |
| viol_bank | output | BA_W | Bank of the illegal command |

## Verification
All outputs are registered, so each result for a command is due exactly one rising edge after that command is presented. Timer boundaries follow from that edge count: READ becomes legal `T_RCD` cycles after ACTIVATE, ACTIVATE becomes legal `T_RP` cycles after PRECHARGE, and a burst ends BL/2 cycles after its command. The bench changes inputs on the falling edge and compares the outputs on the next falling edge, half a period after the edge that registered them. A bank-state model in the bench predicts the result of each command from the state it held before that command.

// File: rtl/ddr2_cmd_legality_mon.sv
module ddr2_cmd_legality_mon #(
  parameter int NUM_BANKS = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] ba,
  input  logic [2:0]               addr_lo,
  output logic                     cmd_seen,
  output logic [2:0]               cmd_code,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] cmd_bank,
  output logic                     viol,
  output logic [2:0]               viol_cmd,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] viol_bank
);
  localparam int BA_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_MAX = (T_RCD > T_RP) ? ((T_RCD > 4) ? T_RCD : 4) : ((T_RP > 4) ? T_RP : 4);
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam logic [2:0] C_DESEL = 3'd0, C_NOP = 3'd1, C_ACT = 3'd2, C_RD = 3'd3,
                         C_WR = 3'd4, C_PRE = 3'd5, C_REF = 3'd6, C_LMR = 3'd7;

  localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] BL4_LD = CW'(1);
  localparam logic [CW-1:0] BL8_LD = CW'(3);

  typedef enum logic [2:0] {S_IDLE, S_ACTV, S_ROW, S_RD, S_WR, S_PREC} bank_st_e;

  logic       cke_q;
  logic       valid;
  logic       issued;
  logic       bl8;
  logic       legal;
  logic [2:0] cmd;
  bank_st_e   cur;
  logic [NUM_BANKS-1:0][2:0] st_v;
  logic [NUM_BANKS-1:0]      bank_idle;

  assign valid  = cke && cke_q;
  assign issued = valid && !cs_n;

  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_LMR;
        default: cmd = C_NOP;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_st_e      st;
    logic [CW-1:0] cnt;
    logic          hit;
    logic          timed;

    assign hit   = issued && (ba == BA_W'(g)) &&
                   (cmd == C_ACT || cmd == C_RD || cmd == C_WR || cmd == C_PRE);
    assign timed = (st == S_ACTV) || (st == S_PREC) || (st == S_RD) || (st == S_WR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (hit) begin
        unique case (cmd)
          C_ACT: begin
            st  <= (T_RCD > 1) ? S_ACTV : S_ROW;
            cnt <= RCD_LD;
          end
          C_RD: begin
            st  <= S_RD;
            cnt <= bl8 ? BL8_LD : BL4_LD;
          end
          C_WR: begin
            st  <= S_WR;
            cnt <= bl8 ? BL8_LD : BL4_LD;
          end
          default: begin
            st  <= (T_RP > 1) ? S_PREC : S_IDLE;
            cnt <= RP_LD;
          end
        endcase
      end else if (timed) begin
        if (cnt <= CW'(1)) st <= (st == S_PREC) ? S_IDLE : S_ROW;
        if (cnt != '0) cnt <= cnt - CW'(1);
      end
    end

    assign st_v[g]      = st;
    assign bank_idle[g] = (st == S_IDLE);
  end

  assign cur = bank_st_e'(st_v[ba]);

  always_comb begin
    unique case (cmd)
      C_ACT, C_REF, C_LMR: legal = (cur == S_IDLE);
      C_RD, C_WR, C_PRE:   legal = (cur == S_ROW) || (bl8 && (cur == S_RD || cur == S_WR));
      default:             legal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      bl8       <= 1'b0;
      cmd_seen  <= 1'b0;
      cmd_code  <= C_DESEL;
      cmd_bank  <= '0;
      viol      <= 1'b0;
      viol_cmd  <= C_DESEL;
      viol_bank <= '0;
    end else begin
      cke_q    <= cke;
      cmd_seen <= valid;
      cmd_code <= valid ? cmd : C_DESEL;
      cmd_bank <= valid ? ba : '0;
      viol     <= issued && !legal;
      if (issued && !legal) begin
        viol_cmd  <= cmd;
        viol_bank <= ba;
      end
      if (issued && cmd == C_LMR && ba == '0) begin
        if (addr_lo == 3'b011) bl8 <= 1'b1;
        else if (addr_lo == 3'b010) bl8 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr2_cmd_legality_chk.sv
module ddr2_cmd_legality_chk #(
  parameter int NB   = 8,
  parameter int BA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic [NB-1:0]   bank_idle,
  input logic            cmd_seen,
  input logic [2:0]      cmd_code,
  input logic [BA_W-1:0] cmd_bank,
  input logic            viol,
  input logic [2:0]      viol_cmd,
  input logic [BA_W-1:0] viol_bank
);
  AST_FLAG_MATCHES_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (cmd_seen && viol_cmd == cmd_code && viol_bank == cmd_bank)); // R10
  AST_FLAG_NEVER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_cmd != 3'd0 && viol_cmd != 3'd1)); // R10
  AST_CKE_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (!cmd_seen && !viol)); // R2
  AST_DESEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> !viol); // R3
  AST_IDLE_ACT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && cas_n && we_n && bank_idle[ba]) |=> !viol); // R4
endmodule

bind ddr2_cmd_legality_mon ddr2_cmd_legality_chk #(.NB(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .bank_idle(bank_idle), .cmd_seen(cmd_seen), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .viol(viol), .viol_cmd(viol_cmd), .viol_bank(viol_bank)
);

// File: tb/test_ddr2_cmd_legality_mon.sv
module test_ddr2_cmd_legality_mon;
  localparam int NB = 8, RCD = 3, RP = 3, BW = 3;
  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_LMR = 3'b000;
  localparam int SI = 0, SA = 1, SR = 2, SRD = 3, SW = 4, SP = 5;

  logic clk = 0, rst_n = 0, cke = 0, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [BW-1:0] ba = '0;
  logic [2:0] addr_lo = '0;
  logic cmd_seen, viol;
  logic [2:0] cmd_code, viol_cmd;
  logic [BW-1:0] cmd_bank, viol_bank;

  int nchk = 0, nbad = 0;
  bit finished = 0;
  int mst[NB];
  int mcnt[NB];
  bit mbl8, mckeq;

  always #4 clk = ~clk;

  ddr2_cmd_legality_mon #(.NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP)) i_ddr2_cmd_legality_mon (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr_lo(addr_lo), .cmd_seen(cmd_seen), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .viol(viol), .viol_cmd(viol_cmd), .viol_bank(viol_bank));

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dec(bit cs, logic [2:0] p);
    if (cs) return 0;
    case (p)
      P_ACT: return 2;
      P_RD:  return 3;
      P_WR:  return 4;
      P_PRE: return 5;
      P_REF: return 6;
      P_LMR: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit m_legal(int c, int s, bit b8);
    if (c == 2 || c == 6 || c == 7) return s == SI;
    if (c >= 3 && c <= 5) return (s == SR) || (b8 && (s == SRD || s == SW));
    return 1;
  endfunction

  task automatic cyc(bit ck, bit cs, logic [2:0] p, int b, logic [2:0] a);
    bit v, ev;
    int c, ec, eb;
    string tg, tv;
    v  = ck && mckeq;
    c  = dec(cs, p);
    ev = v && !cs && !m_legal(c, mst[b], mbl8);
    ec = v ? c : 0;
    eb = v ? b : 0;
    tg = !v ? "R2" : (cs ? "R3" : "R1");
    tv = !v ? "R2" : (cs ? "R3" : "R10");
    for (int k = 0; k < NB; k++) begin
      if (v && !cs && k == b && c >= 2 && c <= 5) begin
        if (c == 2) begin mst[k] = (RCD > 1) ? SA : SR; mcnt[k] = RCD - 1; end
        else if (c == 3) begin mst[k] = SRD; mcnt[k] = mbl8 ? 3 : 1; end
        else if (c == 4) begin mst[k] = SW;  mcnt[k] = mbl8 ? 3 : 1; end
        else begin mst[k] = (RP > 1) ? SP : SI; mcnt[k] = RP - 1; end
      end else if (mst[k] == SA || mst[k] == SP || mst[k] == SRD || mst[k] == SW) begin
        if (mcnt[k] <= 1) mst[k] = (mst[k] == SP) ? SI : SR;
        if (mcnt[k] != 0) mcnt[k]--;
      end
    end
    if (v && !cs && c == 7 && b == 0) begin
      if (a == 3'b011) mbl8 = 1;
      else if (a == 3'b010) mbl8 = 0;
    end
    mckeq = ck;
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = p; ba = BW'(b); addr_lo = a;
    @(posedge clk);
    @(negedge clk);
    chk(cmd_seen == v, tg, cmd_seen, v);
    chk(cmd_code == 3'(ec), tg, cmd_code, ec);
    chk(cmd_bank == BW'(eb), tg, cmd_bank, eb);
    chk(viol == ev, tv, viol, ev);
    if (ev) begin
      chk(viol_cmd == 3'(c), "R10", viol_cmd, c);
      chk(viol_bank == BW'(b), "R10", viol_bank, b);
    end
  endtask

  task automatic run(logic [2:0] p, int b);
    cyc(1, 0, p, b, 3'd0);
  endtask

  task automatic want(bit e, string tag);
    chk(viol == e, tag, viol, e);
  endtask

  function automatic logic [2:0] pick_legal(int s);
    int r;
    r = $urandom_range(99, 0);
    if (s == SI) return (r < 85) ? P_ACT : P_REF;
    if (s == SR || ((s == SRD || s == SW) && mbl8))
      return (r < 40) ? P_RD : ((r < 75) ? P_WR : P_PRE);
    return P_NOP;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NB; k++) begin mst[k] = SI; mcnt[k] = 0; end
    mbl8 = 0; mckeq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_seen == 0, "R1", cmd_seen, 0);
    chk(viol == 0, "R10", viol, 0);
    mckeq = 0;
    cyc(1, 0, P_NOP, 0, 0);
    chk(cmd_seen == 0, "R2", cmd_seen, 0);
    run(P_NOP, 0);
    chk(cmd_code == 3'd1, "R1", cmd_code, 1);

    run(P_ACT, 1); want(0, "R4");
    run(P_NOP, 1);
    run(P_WR, 1);  want(1, "R5");
    chk(viol_cmd == 3'd4, "R10", viol_cmd, 4);
    run(P_NOP, 1); want(0, "R10");
    run(P_RD, 1);  want(0, "R5");

    run(P_ACT, 2); run(P_NOP, 2); run(P_NOP, 2);
    run(P_RD, 2);  want(0, "R5");
    run(P_RD, 2);  want(1, "R7");
    run(P_NOP, 2);
    run(P_PRE, 2); want(0, "R6");
    run(P_NOP, 2);
    run(P_ACT, 2); want(1, "R6");
    run(P_NOP, 2); run(P_NOP, 2); run(P_NOP, 2);
    run(P_PRE, 2); want(0, "R6");
    run(P_NOP, 2); run(P_NOP, 2);
    run(P_ACT, 2); want(0, "R6");
    run(P_ACT, 2); want(1, "R4");
    run(P_LMR, 2); want(1, "R4");
    run(P_REF, 6); want(0, "R4");

    run(P_RD, 7);  want(1, "R11");
    run(P_NOP, 7); run(P_NOP, 7);
    run(P_PRE, 0); want(1, "R11");
    run(P_NOP, 0); run(P_NOP, 0); run(P_NOP, 0);

    cyc(0, 0, P_ACT, 3, 0); want(0, "R2");
    cyc(1, 0, P_RD, 3, 0);
    chk(cmd_seen == 0, "R2", cmd_seen, 0);
    run(P_RD, 3);  want(1, "R2");
    run(P_NOP, 3); run(P_NOP, 3);

    cyc(1, 1, P_ACT, 4, 0); want(0, "R3");
    chk(cmd_code == 3'd0, "R3", cmd_code, 0);
    run(P_RD, 4);  want(1, "R3");
    run(P_NOP, 4); run(P_NOP, 4);

    cyc(1, 0, P_LMR, 0, 3'b011); want(0, "R9");
    cyc(1, 0, P_LMR, 0, 3'b110); want(0, "R9");
    run(P_ACT, 5); run(P_NOP, 5); run(P_NOP, 5);
    run(P_RD, 5);  want(0, "R8");
    run(P_RD, 5);  want(0, "R8");
    run(P_WR, 5);  want(0, "R8");
    run(P_PRE, 5); want(0, "R8");
    run(P_NOP, 5); run(P_NOP, 5); run(P_NOP, 5);
    cyc(1, 0, P_LMR, 0, 3'b010); want(0, "R9");
    run(P_ACT, 5); run(P_NOP, 5); run(P_NOP, 5);
    run(P_RD, 5);  want(0, "R9");
    run(P_WR, 5);  want(1, "R9");
    run(P_NOP, 5); run(P_NOP, 5);

    for (int i = 0; i < 4000; i++) begin
      int b;
      bit ck, cs;
      logic [2:0] p, a;
      b  = $urandom_range(NB - 1, 0);
      ck = ($urandom_range(99, 0) < 93);
      cs = ($urandom_range(99, 0) < 8);
      if ($urandom_range(99, 0) < 70) p = pick_legal(mst[b]);
      else p = 3'($urandom_range(7, 0));
      a = ($urandom_range(1, 0) == 1) ? 3'($urandom_range(3, 2)) : 3'($urandom_range(7, 0));
      cyc(ck, cs, p, b, a);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule